// File: doc/BRIEF.md
# Reference Input Pre-Divider for Phase Comparison

This block sits on a single reference clock input of a timing source. It brings the reference into the system clock domain, reduces it to the rate at which a digital PLL compares phase, and emits a one-cycle event for each comparison instant. The event rate is chosen by a per-input configuration byte. One setting passes every rising edge of the reference straight through. Another treats an input that already runs at 8 kHz as the comparison signal. A third divides a supported spot frequency down to 8 kHz. The last divides the reference by a programmable ratio N+1, where N is a 14-bit value shared by all inputs.

An edge-select input chooses which edge of the 8 kHz signal counts as significant. For a divided reference, the derived 8 kHz wave is high for the first half of each divide period. Selecting the falling edge therefore moves the event to the middle of the period. A settings combination that cannot yield 8 kHz raises a configuration error flag and suppresses all events. Any change to a setting that affects division restarts the divider, so the next output period is complete.

Top module: `refdiv_prediv`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, `cmp_evt` and `cfg_err` are low, even if an illegal configuration is applied.
- R2: With configuration bits 7 and 6 both clear, one event is produced for every rising edge of the reference. The edge select has no effect in this setting.
- R3: With bit 6 set, bit 7 clear and frequency code (bits 3:0) equal to 0, the reference is itself the 8 kHz signal. An event follows each rising edge when `edge_fall` is 0, and each falling edge when `edge_fall` is 1.
- R4: With bit 6 set, bit 7 clear and a frequency code from 1 to 7, the reference is divided by the spot ratio for that code. The ratios are: 1 gives 256 (193 with the SONET parameter), 2 gives 810, 3 gives 2430, 4 gives 3240, 5 gives 4860, 6 gives 6480 and 7 gives 9720.
- R5: With bits 7 and 6 both set and 0 < N < 16383, the reference is divided by N+1. With `edge_fall` at 0, events occur at rising-edge counts R, 2R, 3R and so on, where R is the ratio and counting starts after the last configuration change.
- R6: With `edge_fall` at 1 in a divided setting, events occur at rising-edge counts floor(R/2), floor(R/2)+R and so on.
- R7: A change to bits 7, 6 or 3:0, to N while in DivN mode, or to `edge_fall` restarts the divider, so the next event comes after a full count.
- R8: Bits 5:4 (monitor identifier) have no effect on events. Changing them mid-stream neither shifts nor restarts the divider.
- R9: `cfg_err` is high, and no events are produced, when any of these holds: bit 7 is set with bit 6 clear; bit 7 is set with N equal to 0 or 16383; bit 6 is set with bit 7 clear and a code above 7. The flag follows the configuration one cycle later.
- R10: Each event is a single system-clock cycle high. It appears three system clock cycles after the reference edge that causes it, that is, two synchroniser stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| cfg_byte | input | 8 | Per-input configuration: [7] DivN, [6] lock to 8 kHz, [5:4] monitor ID, [3:0] frequency code |
| div_n | input | 14 | Shared DivN value N; ratio is N+1 |
| edge_fall | input | 1 | 1 selects the falling edge of the 8 kHz signal |
| cmp_evt | output | 1 | One-cycle phase comparison event |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench sweeps N from 1 to 12 with both edge selections. At N=1 the mid-period event sits on the very first edge. A design that computed the midpoint with an off-by-one error, or wrapped at N instead of N+1, would place events one edge early or late. Full spot-code periods, including the 9720 ratio, catch a wrong ratio entry or a counter that is too narrow and wraps early. A configuration change in the middle of a count exposes a divider that keeps its old count and fires early. A change to the monitor identifier exposes the opposite fault, a divider restarted by a field it should ignore. The illegal settings at N=0 and N=16383 would, if missed, yield events at a wrong rate instead of silence with the error flag raised.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic [1:0] {
    RD_OFF  = 2'd0,
    RD_PASS = 2'd1,
    RD_EDGE = 2'd2,
    RD_DIV  = 2'd3
  } rd_mode_e;

  // Comparison rate in kHz; a spot ratio is the spot rate over this rate.
  localparam int unsigned CMP_RATE_KHZ = 8;

  // Spot rate in kHz for each frequency code; zero marks an unsupported code.
  function automatic int unsigned spot_khz(input logic [3:0] code, input logic sonet);
    case (code)
      4'd1:    spot_khz = sonet ? 1544 : 2048;
      4'd2:    spot_khz = 6480;
      4'd3:    spot_khz = 19440;
      4'd4:    spot_khz = 25920;
      4'd5:    spot_khz = 38880;
      4'd6:    spot_khz = 51840;
      4'd7:    spot_khz = 77760;
      default: spot_khz = 0;
    endcase
  endfunction

  function automatic int unsigned spot_ratio(input logic [3:0] code, input logic sonet);
    spot_ratio = spot_khz(code, sonet) / CMP_RATE_KHZ;
  endfunction

endpackage

// File: rtl/refdiv_sync.sv
module refdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise,
  output logic fall
);
  localparam int CW = STAGES + 1;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[CW-2:0], ref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

  // R10: a detected edge lasts one cycle
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_fall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
#(
  parameter int NW    = 14,
  parameter bit SONET = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_byte,
  input  logic [NW-1:0] div_n,
  input  logic          edge_fall,
  output rd_mode_e      mode,
  output logic [NW-1:0] term,
  output logic [NW-1:0] half,
  output logic          fall_sel,
  output logic          cfg_chg,
  output logic          err_nxt
);
  localparam logic [NW-1:0] N_MAX = {NW{1'b1}};
  localparam int            KW    = 7 + NW;

  logic          divn_en;
  logic          lock8k;
  logic [3:0]    fcode;
  int unsigned   spot;
  logic [NW:0]   n_plus;
  logic [KW-1:0] key;
  logic [KW-1:0] key_q;

  always_comb begin
    divn_en  = cfg_byte[7];
    lock8k   = cfg_byte[6];
    fcode    = cfg_byte[3:0];
    spot     = spot_ratio(fcode, SONET);
    n_plus   = {1'b0, div_n} + 1'b1;
    fall_sel = edge_fall;
    mode     = RD_OFF;
    term     = '0;
    half     = '0;
    err_nxt  = 1'b0;
    if (divn_en) begin
      if (!lock8k || div_n == '0 || div_n == N_MAX) begin
        err_nxt = 1'b1;
      end else begin
        mode = RD_DIV;
        term = div_n;
        half = n_plus[NW:1];
      end
    end else if (lock8k) begin
      if (fcode == 4'd0) begin
        mode = RD_EDGE;
      end else if (spot != 0) begin
        mode = RD_DIV;
        term = NW'(spot - 1);
        half = NW'(spot >> 1);
      end else begin
        err_nxt = 1'b1;
      end
    end else begin
      mode = RD_PASS;
    end
  end

  // Only fields that shape the division take part in restart detection.
  always_comb begin
    key     = {cfg_byte[7:6], cfg_byte[3:0], (divn_en ? div_n : {NW{1'b0}}), edge_fall};
    cfg_chg = (key != key_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key;
  end

  // R6: the mid-period point lies strictly inside a divide period
  assert_half_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_DIV) |-> (half != '0 && half <= term));

endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter int NW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_mode_e      mode,
  input  logic [NW-1:0] term,
  input  logic [NW-1:0] half,
  input  logic          fall_sel,
  input  logic          cfg_chg,
  input  logic          rise,
  input  logic          fall,
  output logic          evt_nxt
);
  logic [NW-1:0] cnt_q;
  logic [NW-1:0] cnt_nxt;
  logic [NW-1:0] cnt_inc;
  logic          wrap;
  logic          cnt_en;

  always_comb begin
    wrap    = (cnt_q == term);
    cnt_inc = wrap ? '0 : cnt_q + 1'b1;
    cnt_en  = cfg_chg | ((mode == RD_DIV) & rise);
    cnt_nxt = cfg_chg ? '0 : cnt_inc;
  end

  always_comb begin
    evt_nxt = 1'b0;
    if (!cfg_chg) begin
      case (mode)
        RD_PASS: evt_nxt = rise;
        RD_EDGE: evt_nxt = fall_sel ? fall : rise;
        RD_DIV:  evt_nxt = rise & (fall_sel ? (cnt_inc == half) : wrap);
        default: evt_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // R5: the count never passes the terminal value of a settled ratio
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RD_DIV && !cfg_chg) |-> (cnt_q <= term));
  // R7: a relevant configuration change restarts the count
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt_q == '0));

endmodule

// File: rtl/refdiv_prediv.sv
module refdiv_prediv
  import refdiv_pkg::*;
#(
  parameter int NW          = 14,
  parameter int SYNC_STAGES = 2,
  parameter bit SONET       = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic [7:0]    cfg_byte,
  input  logic [NW-1:0] div_n,
  input  logic          edge_fall,
  output logic          cmp_evt,
  output logic          cfg_err
);
  rd_mode_e      mode;
  logic [NW-1:0] term;
  logic [NW-1:0] half;
  logic          fall_sel;
  logic          cfg_chg;
  logic          err_nxt;
  logic          rise;
  logic          fall;
  logic          evt_nxt;
  logic          evt_q;
  logic          err_q;

  refdiv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .rise   (rise),
    .fall   (fall)
  );

  refdiv_cfg #(.NW(NW), .SONET(SONET)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_byte  (cfg_byte),
    .div_n     (div_n),
    .edge_fall (edge_fall),
    .mode      (mode),
    .term      (term),
    .half      (half),
    .fall_sel  (fall_sel),
    .cfg_chg   (cfg_chg),
    .err_nxt   (err_nxt)
  );

  refdiv_count #(.NW(NW)) i_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .term     (term),
    .half     (half),
    .fall_sel (fall_sel),
    .cfg_chg  (cfg_chg),
    .rise     (rise),
    .fall     (fall),
    .evt_nxt  (evt_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      evt_q <= evt_nxt;
      err_q <= err_nxt;
    end
  end

  assign cmp_evt = evt_q;
  assign cfg_err = err_q;

  // R9: an illegal setting produces no events
  assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_err && cmp_evt));
  // R10: events are single-cycle pulses
  assert_evt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> !cmp_evt);

endmodule

// File: tb/test_refdiv_prediv.sv
module test_refdiv_prediv;
  logic        clk;
  logic        rst_n;
  logic        ref_in;
  logic [7:0]  cfg_byte;
  logic [13:0] div_n;
  logic        edge_fall;
  logic        cmp_evt;
  logic        cfg_err;

  int checks;
  int errors;
  int cyc;
  bit done;

  // expectation state
  int    e_kind;   // 0 silent, 1 every rise, 2 8k edge, 3 divided
  int    e_r;
  int    e_half;
  int    e_sel;
  int    idx;
  string e_tag;

  refdiv_prediv i_refdiv_prediv (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .cfg_byte  (cfg_byte),
    .div_n     (div_n),
    .edge_fall (edge_fall),
    .cmp_evt   (cmp_evt),
    .cfg_err   (cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int want(input int i, input bit high);
    case (e_kind)
      1:       want = high ? 1 : 0;
      2:       want = (e_sel != 0) ? (high ? 0 : 1) : (high ? 1 : 0);
      3:       want = (high && ((i % e_r) == ((e_sel != 0) ? e_half : 0))) ? 1 : 0;
      default: want = 0;
    endcase
  endfunction

  // Drive one reference level for four system cycles; an event from the
  // edge appears three cycles later, inside this window.
  task automatic phase(input bit lvl);
    int n;
    n = 0;
    ref_in = lvl;
    repeat (4) begin
      @(negedge clk);
      if (cmp_evt) n++;
    end
    check(n == want(idx, lvl), e_tag,
          $sformatf("events at edge %0d level %0d", idx, lvl), n, want(idx, lvl));
  endtask

  task automatic periods(input int n);
    for (int p = 0; p < n; p++) begin
      idx++;
      phase(1'b1);
      phase(1'b0);
    end
  endtask

  task automatic setup(input logic [7:0] cb, input int nval, input bit sel,
                       input int kind, input int r, input string tag);
    cfg_byte  = cb;
    div_n     = 14'(nval);
    edge_fall = sel;
    e_kind    = kind;
    e_r       = r;
    e_half    = r >> 1;
    e_sel     = sel;
    e_tag     = tag;
    repeat (3) @(negedge clk);
    idx = 0;
    check(cfg_err == (kind == 0), tag, "cfg_err", cfg_err, (kind == 0) ? 1 : 0);
  endtask

  initial begin
    done = 1'b0;
    wait (cyc >= 195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 195000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    ref_in    = 1'b0;
    cfg_byte  = 8'h80;
    div_n     = 14'd5;
    edge_fall = 1'b0;
    idx       = 0;
    e_kind    = 0;
    e_r       = 1;
    e_half    = 0;
    e_sel     = 0;
    e_tag     = "R1";

    // R1: quiet outputs during reset with an illegal setting present
    repeat (3) begin
      @(negedge clk);
      ref_in = ~ref_in;
      check(cmp_evt == 1'b0 && cfg_err == 1'b0, "R1", "outputs in reset",
            {cmp_evt, cfg_err}, 0);
    end
    ref_in = 1'b0;
    cfg_byte = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmp_evt == 1'b0 && cfg_err == 1'b0, "R1", "outputs after reset",
          {cmp_evt, cfg_err}, 0);

    // R2: pass-through, edge select ignored
    setup(8'h05, 0, 1'b0, 1, 1, "R2");
    periods(5);
    setup(8'h05, 0, 1'b1, 1, 1, "R2");
    periods(5);

    // R3: 8 kHz input, edge select
    setup(8'h40, 0, 1'b0, 2, 1, "R3");
    periods(4);
    setup(8'h40, 0, 1'b1, 2, 1, "R3");
    periods(4);

    // R5 and R6: DivN sweep over both edges
    for (int n = 1; n <= 12; n++) begin
      setup(8'hC1, n, 1'b0, 3, n + 1, "R5");
      periods(2 * (n + 1) + 1);
      setup(8'hC1, n, 1'b1, 3, n + 1, "R6");
      periods(2 * (n + 1) + 1);
    end
    // R5: DivN example for a 2.000 MHz input
    setup(8'hC1, 249, 1'b0, 3, 250, "R5");
    periods(251);

    // R7: restart on N change mid-count
    setup(8'hC1, 5, 1'b0, 3, 6, "R7");
    periods(3);
    setup(8'hC1, 6, 1'b0, 3, 7, "R7");
    periods(15);
    // R7: restart on edge select change mid-count
    setup(8'hC1, 4, 1'b0, 3, 5, "R7");
    periods(3);
    setup(8'hC1, 4, 1'b1, 3, 5, "R7");
    periods(11);

    // R8: monitor ID change keeps the running count
    setup(8'hC1, 4, 1'b0, 3, 5, "R8");
    periods(3);
    e_tag = "R8";
    cfg_byte = 8'hF1;
    repeat (3) @(negedge clk);
    check(cfg_err == 1'b0, "R8", "cfg_err after ID change", cfg_err, 0);
    periods(12);

    // R9: illegal settings
    setup(8'h80, 5, 1'b0, 0, 1, "R9");
    periods(3);
    setup(8'hC0, 0, 1'b0, 0, 1, "R9");
    periods(3);
    setup(8'hC0, 16383, 1'b0, 0, 1, "R9");
    periods(3);
    setup(8'h48, 7, 1'b0, 0, 1, "R9");
    periods(3);
    setup(8'hC0, 3, 1'b1, 3, 4, "R9");
    periods(9);

    // R4: spot ratios
    setup(8'h41, 0, 1'b0, 3, 256, "R4");
    periods(257);
    setup(8'h52, 0, 1'b1, 3, 810, "R4");
    periods(811);
    setup(8'h43, 0, 1'b0, 3, 2430, "R4");
    periods(2430);
    setup(8'h47, 0, 1'b0, 3, 9720, "R4");
    periods(9720);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule